// File: doc/BRIEF.md
# Metastability Event Monitor

This block is an on-chip test structure that measures how often a sampling flip-flop goes metastable. A launch register captures an asynchronous input on the rising clock edge. Its output, optionally passed through `SETTLE_STAGES` extra rising-edge stages, feeds two probes. One probe is clocked on the rising edge and one on the falling edge. A falling-edge flag register records a one whenever the two probes disagree. That one can only appear when the launch output settles late, after the falling edge and before the next rising edge.

During a window whose length software sets in clock cycles, the block counts three things: flagged events, rising clock edges, and transitions of the asynchronous input. The input transitions are seen only through a separate two-stage synchronizer and edge detector. Software reads the three counts after the window and derives the clock rate, the data rate and the failure rate for a reliability estimate. Raising `SETTLE_STAGES` gives the launch output more time to resolve before the comparison.

A small state machine runs the window. It has three states:
- `ST_IDLE`: the state after reset.
- `ST_MEASURE`: the window is open.
- `ST_DONE`: the window has closed and the counts are frozen.

It has four transitions:
- T_ARM: a start with a nonzero length, from any state, goes to `ST_MEASURE`.
- T_EMPTY: a start with length zero goes to `ST_DONE`.
- T_EXPIRE: `ST_MEASURE` goes to `ST_DONE` on the last cycle of the window.
- T_HOLD: in every other case the state stays where it is.

Top module: `meta_event_monitor`

## Requirements
- R1: A synchronous reset clears all three counts, all three overflow flags and `done`, and places the controller in `ST_IDLE`.
- R2: A start pulse sampled on a rising edge clears every count and overflow flag and loads `window_len`. `clk_count` then increases by one on each rising edge spent in `ST_MEASURE`.
- R3: After exactly `window_len` rising edges in `ST_MEASURE`, `done` rises and stays high until the next start. While `done` is high, no count changes. A start with `window_len` equal to 0 raises `done` on the next edge with all counts at zero.
- R4: Each transition of `async_din` that stays stable for at least two cycles adds exactly one to `edge_count`. A transition first sampled at rising edge n is counted at rising edge n+2, provided that edge is inside the window.
- R5: When the launch register output settles after a falling edge and before the next rising edge, `fail_count` increases by exactly one. The increment lands on the fourth rising edge after that late settling, provided that edge is inside the window.
- R6: An input whose transitions reach the launch register cleanly at the rising edge never produces an event, so `fail_count` stays 0.
- R7: A count at its all-ones maximum stays there when another increment is due, and that increment sets the count's overflow flag. The flag stays set until the next start clears it.
- R8: A start arriving while a window is open discards the current counts and begins a new window of the newly supplied length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| async_din | input | 1 | Asynchronous data under test |
| start | input | 1 | One-cycle pulse that opens a new window |
| window_len | input | WIN_W | Window length in clock cycles, taken on start |
| clk_count | output | CNT_W | Rising edges counted in the window |
| edge_count | output | CNT_W | Input transitions counted in the window |
| fail_count | output | CNT_W | Metastable events counted in the window |
| clk_ovf | output | 1 | `clk_count` saturated |
| edge_ovf | output | 1 | `edge_count` saturated |
| fail_ovf | output | 1 | `fail_count` saturated |
| done | output | 1 | Window closed, counts frozen |

## Verification
The hardest condition to reach is a real event: in zero-delay simulation the launch register always settles exactly at the rising edge, so the comparison pair never disagrees from the ports alone. The bench forces the launch register output high shortly after a falling edge and releases it just after the next rising edge, which mimics a register that resolves late. It then expects exactly one count, three rising edges after the next falling edge has captured the flag. Injections are also placed after the window has closed, to show that they leave the frozen counts alone.

// File: rtl/msm_pkg.sv
package msm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_DONE    = 2'd2
    } msm_state_t;

endpackage

// File: rtl/msm_sat_counter.sv
module msm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         bump,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] count_q;
    logic         ovf_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (bump) begin
            if (count_q == MAXV) begin
                ovf_q <= 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count = count_q;
    assign ovf   = ovf_q;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_q == MAXV && !clear) |=> count_q == MAXV); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clear) |=> ovf_q); // R7

endmodule

// File: rtl/msm_edge_tap.sv
module msm_edge_tap (
    input  logic clk,
    input  logic rst,
    input  logic din_async,
    output logic edge_hit
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= din_async;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign edge_hit = s2_q ^ prev_q;

endmodule

// File: rtl/msm_probe.sv
module msm_probe #(
    parameter int SETTLE_STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic din_async,
    output logic event_hit
);
    localparam int EV_SYNC = 2;

    logic launch_q;
    logic tap;
    logic samp_rise_q;
    logic samp_fall_q;
    logic event_q;
    logic [EV_SYNC-1:0] ev_sync_q;

    // launch register: the flop whose resolution is being measured
    always_ff @(posedge clk) begin
        if (rst) launch_q <= 1'b0;
        else     launch_q <= din_async;
    end

    generate
        if (SETTLE_STAGES == 0) begin : g_direct
            assign tap = launch_q;
        end else begin : g_settle
            logic [SETTLE_STAGES-1:0] dly_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    dly_q <= '0;
                end else begin
                    dly_q[0] <= launch_q;
                    for (int i = 1; i < SETTLE_STAGES; i++) dly_q[i] <= dly_q[i-1];
                end
            end
            assign tap = dly_q[SETTLE_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) samp_rise_q <= 1'b0;
        else     samp_rise_q <= tap;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            samp_fall_q <= 1'b0;
            event_q     <= 1'b0;
        end else begin
            samp_fall_q <= tap;
            event_q     <= samp_rise_q ^ samp_fall_q;
        end
    end

    // bring the falling-edge flag back into the rising-edge domain
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_sync_q <= '0;
        end else begin
            ev_sync_q[0] <= event_q;
            for (int i = 1; i < EV_SYNC; i++) ev_sync_q[i] <= ev_sync_q[i-1];
        end
    end

    assign event_hit = ev_sync_q[EV_SYNC-1];

    AST_EVENT_RELAY: assert property (@(posedge clk) disable iff (rst)
        event_hit == $past(event_q, 2)); // R5

endmodule

// File: rtl/meta_event_monitor.sv
module meta_event_monitor
    import msm_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int WIN_W         = 32,
    parameter int SETTLE_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             async_din,
    input  logic             start,
    input  logic [WIN_W-1:0] window_len,
    output logic [CNT_W-1:0] clk_count,
    output logic [CNT_W-1:0] edge_count,
    output logic [CNT_W-1:0] fail_count,
    output logic             clk_ovf,
    output logic             edge_ovf,
    output logic             fail_ovf,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

    msm_state_t       state_q, state_d;
    logic [WIN_W-1:0] remain_q;
    logic             measuring;
    logic             edge_hit;
    logic             event_hit;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_MEASURE: if (remain_q == WIN_ONE) state_d = ST_DONE;  // T_EXPIRE
            ST_DONE:    state_d = ST_DONE;
        endcase
        if (start) begin
            state_d = (window_len == '0) ? ST_DONE : ST_MEASURE;     // T_EMPTY / T_ARM
        end
    end

    // outputs decoded from the state
    always_comb begin
        measuring = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_MEASURE: measuring = 1'b1;
            ST_DONE:    done = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            remain_q <= '0;
        else if (start)     remain_q <= window_len;
        else if (measuring) remain_q <= remain_q - 1'b1;
    end

    msm_probe #(.SETTLE_STAGES(SETTLE_STAGES)) u_probe (
        .clk       (clk),
        .rst       (rst),
        .din_async (async_din),
        .event_hit (event_hit)
    );

    msm_edge_tap u_edges (
        .clk       (clk),
        .rst       (rst),
        .din_async (async_din),
        .edge_hit  (edge_hit)
    );

    msm_sat_counter #(.W(CNT_W)) u_clk_cnt (
        .clk (clk), .rst (rst), .clear (start),
        .bump (measuring), .count (clk_count), .ovf (clk_ovf)
    );

    msm_sat_counter #(.W(CNT_W)) u_edge_cnt (
        .clk (clk), .rst (rst), .clear (start),
        .bump (measuring && edge_hit), .count (edge_count), .ovf (edge_ovf)
    );

    msm_sat_counter #(.W(CNT_W)) u_fail_cnt (
        .clk (clk), .rst (rst), .clear (start),
        .bump (measuring && event_hit), .count (fail_count), .ovf (fail_ovf)
    );

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && window_len != '0) |=> (!done && clk_count == '0 && edge_count == '0
                                         && fail_count == '0 && !clk_ovf)); // R2

    AST_CLK_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEASURE && !start && clk_count != CNT_MAX)
            |=> clk_count == CNT_W'($past(clk_count) + 1'b1)); // R2

    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(clk_count) && $stable(edge_count)
                              && $stable(fail_count) && done)); // R3

    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (start && window_len == '0) |=> (done && clk_count == '0)); // R3

endmodule

// File: tb/meta_event_monitor_tb.sv
`timescale 1ns/1ps
module meta_event_monitor_tb_top;
    localparam int CW = 6;
    localparam int WW = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic async_din = 1'b0;
    logic start = 1'b0;
    logic [WW-1:0] window_len = '0;
    logic [CW-1:0] clk_count, edge_count, fail_count;
    logic clk_ovf, edge_ovf, fail_ovf, done;

    always #2.5 clk = ~clk;

    meta_event_monitor #(.CNT_W(CW), .WIN_W(WW), .SETTLE_STAGES(0)) dut_i (
        .clk (clk), .rst (rst), .async_din (async_din), .start (start),
        .window_len (window_len), .clk_count (clk_count), .edge_count (edge_count),
        .fail_count (fail_count), .clk_ovf (clk_ovf), .edge_ovf (edge_ovf),
        .fail_ovf (fail_ovf), .done (done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference
    int m_state, m_rem, m_clk, m_edge, m_fail;
    bit m_co, m_eo, m_fo;
    bit dh0, dh1, dh2, ih0, ih1, ih2;
    bit inj_flag = 0;

    task automatic sat_bump(ref int c, ref bit o);
        if (c == MAXC) o = 1; else c = c + 1;
    endtask

    always @(posedge clk) begin
        bit e_now, f_now;
        e_now = (dh1 != dh2);
        f_now = ih2;
        if (rst) begin
            m_state = 0; m_rem = 0; m_clk = 0; m_edge = 0; m_fail = 0;
            m_co = 0; m_eo = 0; m_fo = 0;
        end else if (start) begin
            m_clk = 0; m_edge = 0; m_fail = 0; m_co = 0; m_eo = 0; m_fo = 0;
            m_rem = int'(window_len);
            m_state = (window_len == 0) ? 2 : 1;
        end else if (m_state == 1) begin
            sat_bump(m_clk, m_co);
            if (e_now) sat_bump(m_edge, m_eo);
            if (f_now) sat_bump(m_fail, m_fo);
            if (m_rem == 1) m_state = 2;
            m_rem = m_rem - 1;
        end
        dh2 = dh1; dh1 = dh0; dh0 = rst ? 1'b0 : async_din;
        ih2 = ih1; ih1 = ih0; ih0 = rst ? 1'b0 : inj_flag;
        inj_flag = 0;
    end

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(tag, "clk_count", int'(clk_count), m_clk);
            check(tag, "edge_count", int'(edge_count), m_edge);
            check(tag, "fail_count", int'(fail_count), m_fail);
            check(tag, "clk_ovf", int'(clk_ovf), int'(m_co));
            check(tag, "edge_ovf", int'(edge_ovf), int'(m_eo));
            check(tag, "fail_ovf", int'(fail_ovf), int'(m_fo));
            check(tag, "done", int'(done), int'(m_state == 2));
        end
    end

    task automatic go(int len);
        @(posedge clk); #1;
        window_len = WW'(len);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic din_wave(int period, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (i % period == 0) async_din = ~async_din;
        end
    endtask

    // emulate a launch flop that resolves after the falling edge
    task automatic inject();
        @(negedge clk); #1;
        force dut_i.u_probe.launch_q = 1'b1;
        inj_flag = 1;
        @(posedge clk); #1;
        release dut_i.u_probe.launch_q;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        idle(4);
        @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "clk_count in reset", int'(clk_count), 0);
        check("R1", "fail_count in reset", int'(fail_count), 0);
        @(posedge clk); #1; rst = 1'b0;
        idle(3);

        tag = "R4";
        go(20);
        din_wave(3, 24);
        @(negedge clk);
        check("R2", "clk_count after window", int'(clk_count), 20);
        check("R3", "done after window", int'(done), 1);
        check("R6", "clean input events", int'(fail_count), 0);
        async_din = 1'b0;
        idle(4);

        tag = "R5";
        go(40);
        idle(4);  inject();
        idle(8);  inject();
        idle(8);  inject();
        idle(25);
        @(negedge clk);
        check("R5", "events counted", int'(fail_count), 3);

        tag = "R3";
        go(0);
        idle(2);
        @(negedge clk);
        check("R3", "empty window done", int'(done), 1);
        check("R3", "empty window clk_count", int'(clk_count), 0);
        din_wave(2, 6);
        async_din = 1'b0;
        idle(3); inject(); idle(6);
        @(negedge clk);
        check("R3", "frozen edge_count", int'(edge_count), 0);
        check("R3", "frozen fail_count", int'(fail_count), 0);

        tag = "R8";
        go(30);
        idle(10);
        go(15);
        idle(20);
        @(negedge clk);
        check("R8", "restarted clk_count", int'(clk_count), 15);

        tag = "R7";
        go(100);
        din_wave(1, 105);
        @(negedge clk);
        check("R7", "clk_count saturated", int'(clk_count), MAXC);
        check("R7", "clk_ovf", int'(clk_ovf), 1);
        check("R7", "edge_ovf", int'(edge_ovf), 1);
        async_din = 1'b0;
        go(5);
        @(negedge clk);
        check("R7", "ovf cleared by start", int'(clk_ovf), 0);
        idle(8);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule